// File: doc/BRIEF.md
# PHY Configuration Access Bridge

This block turns a single 32-bit software-visible access register into complete request/acknowledge transactions toward a small PHY configuration register file. Software loads a 6-bit PHY address and a write byte, sets one request bit (write or read), polls until the acknowledge bit goes high, and then clears the request. The acknowledge bit drops again only after that clear. This gives a full four-phase handshake through one shared register, so software needs no other status.

Inside the block, a control engine holds the access register. It drives a PHY-side strobe with direction, address and data, and waits for the PHY's completion pulse. On a read, it captures the returned byte before it raises acknowledge. A model of the PHY register file is also included. It has a parameterised completion latency and holds one 8-bit delay setting at each supported address. Software writes are always accepted in one cycle, so the software side has no back-pressure. The PHY side is the only place where the block waits, and the control engine holds its strobe and operands steady until the PHY reports completion. The same handshake is used when a full list of settings is rewritten, for example after a resume: one entry per transaction.

Top module: `phy_access_bridge`

## Requirements
- R1: Synchronous active-high reset clears both request bits, acknowledge, the address, write-data and read-data fields (whole register reads 0), and every PHY setting (a later read of any supported address returns 0x00).
- R2: The access register reads back as: acknowledge at bit 26, read request at bit 25, write request at bit 24, read byte at bits 23:16, write byte at bits 15:8, address at bits 5:0, all other bits 0.
- R3: Setting only the write request (bit 24) stores the write byte at the addressed PHY setting and raises acknowledge; a later read of that address returns the byte.
- R4: Acknowledge stays high while either request bit is set, and falls at the first clock edge after a software write that clears both request bits is registered.
- R5: A read request (bit 25 alone) places the addressed PHY byte in bits 23:16 no later than the cycle acknowledge rises, and that field holds steady while acknowledge is high.
- R6: Setting both request bits together starts no transaction: acknowledge stays low and no PHY setting changes.
- R7: Software writes made while a transaction is in progress or acknowledge is high update only the two request bits; the address and write-byte fields keep their values.
- R8: Only addresses 0x00 to 0x08 and 0x0B to 0x0D hold settings; a write to any other address completes its handshake but stores nothing, and a read from one returns 0x00.
- R9: Software cannot set the acknowledge bit or the read-byte field: writing ones to bits 26 and 23:16 with no request leaves them 0.
- R10: Acknowledge rises no more than LAT+2 clock cycles after the cycle in which the request write is registered, LAT being the PHY model's completion latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write strobe for the access register |
| sw_wdata | input | 32 | Value software writes to the access register |
| port_rdata | output | 32 | Current value of the access register as software reads it |

## Verification
The bound checker watches every cycle to confirm four things. Acknowledge rises only after a PHY completion pulse. The read byte and the address and data fields stay frozen while acknowledge is held. Acknowledge falls one edge after both requests are seen clear. The PHY strobe never starts from a register holding both request bits, and it never stays busy longer than the latency allows. Only the bench's scenarios can show that data really lands at the right PHY address and comes back on a later read. They also cover unsupported addresses losing their writes, reset wiping the PHY settings, and software being unable to force acknowledge or the read byte. A full rewrite of every setting, one transaction after another, is also run by the bench.

// File: rtl/phy_acc_pkg.sv
package phy_acc_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 6;
  localparam int BYTE_W    = 8;
  localparam int ACK_BIT   = 26;
  localparam int RD_BIT    = 25;
  localparam int WR_BIT    = 24;
  localparam int RDATA_LSB = 16;
  localparam int WDATA_LSB = 8;
  localparam int ADDR_LSB  = 0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_ACKED = 2'd2
  } acc_state_t;

  function automatic logic addr_supported(input logic [ADDR_W-1:0] a);
    return (a <= ADDR_W'(8)) || ((a >= ADDR_W'(11)) && (a <= ADDR_W'(13)));
  endfunction
endpackage

// File: rtl/phy_cfg_regfile.sv
module phy_cfg_regfile
  import phy_acc_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              done,
  output logic [BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(LAT + 1) + 1;

  logic [CNT_W-1:0]  wait_cnt;
  logic [BYTE_W-1:0] cells [DEPTH];

  assign done = req && (wait_cnt == CNT_W'(LAT));

  always_ff @(posedge clk) begin
    if (rst || !req || done) wait_cnt <= '0;
    else                     wait_cnt <= wait_cnt + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    if (addr_supported(ADDR_W'(g))) begin : g_live
      logic [BYTE_W-1:0] val_q;
      always_ff @(posedge clk) begin
        if (rst)
          val_q <= '0;
        else if (done && we && (addr == ADDR_W'(g)))
          val_q <= wdata;
      end
      assign cells[g] = val_q;
    end else begin : g_hole
      assign cells[g] = '0;
    end
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/phy_acc_ctrl.sv
module phy_acc_ctrl
  import phy_acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [WORD_W-1:0] sw_wdata,
  input  logic              phy_done,
  input  logic [BYTE_W-1:0] phy_rdata,
  output logic              phy_req,
  output logic              phy_we,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [BYTE_W-1:0] phy_wdata,
  output logic [WORD_W-1:0] port_word
);
  acc_state_t        state_q;
  logic              wr_q, rd_q, op_wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wbyte_q, rbyte_q;
  logic              ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wbyte_q <= '0;
    end else if (sw_we) begin
      wr_q <= sw_wdata[WR_BIT];
      rd_q <= sw_wdata[RD_BIT];
      if (state_q == ST_IDLE) begin
        addr_q  <= sw_wdata[ADDR_LSB +: ADDR_W];
        wbyte_q <= sw_wdata[WDATA_LSB +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_wr_q <= 1'b0;
      rbyte_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (wr_q ^ rd_q) begin
            state_q <= ST_BUSY;
            op_wr_q <= wr_q;
          end
        end
        ST_BUSY: begin
          if (phy_done) begin
            state_q <= ST_ACKED;
            if (!op_wr_q) rbyte_q <= phy_rdata;
          end
        end
        ST_ACKED: begin
          if (!wr_q && !rd_q) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ack       = (state_q == ST_ACKED);
  assign phy_req   = (state_q == ST_BUSY);
  assign phy_we    = op_wr_q;
  assign phy_addr  = addr_q;
  assign phy_wdata = wbyte_q;

  always_comb begin
    port_word = '0;
    port_word[ACK_BIT] = ack;
    port_word[RD_BIT]  = rd_q;
    port_word[WR_BIT]  = wr_q;
    port_word[RDATA_LSB +: BYTE_W] = rbyte_q;
    port_word[WDATA_LSB +: BYTE_W] = wbyte_q;
    port_word[ADDR_LSB +: ADDR_W]  = addr_q;
  end
endmodule

// File: rtl/phy_access_bridge.sv
module phy_access_bridge
  import phy_acc_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sw_we,
  input  logic [31:0] sw_wdata,
  output logic [31:0] port_rdata
);
  logic              phy_req, phy_we, phy_done;
  logic [ADDR_W-1:0] phy_addr;
  logic [BYTE_W-1:0] phy_wdata, phy_rdata;

  phy_acc_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .sw_we     (sw_we),
    .sw_wdata  (sw_wdata),
    .phy_done  (phy_done),
    .phy_rdata (phy_rdata),
    .phy_req   (phy_req),
    .phy_we    (phy_we),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata),
    .port_word (port_rdata)
  );

  phy_cfg_regfile #(.LAT(LAT)) regs_i (
    .clk   (clk),
    .rst   (rst),
    .req   (phy_req),
    .we    (phy_we),
    .addr  (phy_addr),
    .wdata (phy_wdata),
    .done  (phy_done),
    .rdata (phy_rdata)
  );
endmodule

// File: rtl/phy_access_bridge_chk.sv
module phy_access_bridge_chk
  import phy_acc_pkg::*;
#(
  parameter int LAT = 3
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] port_word,
  input logic        phy_req,
  input logic        phy_done
);
  logic              ack, wr, rd;
  logic [BYTE_W-1:0] rbyte, wbyte;
  logic [ADDR_W-1:0] addr;
  logic [15:0]       busy_cnt;

  assign ack   = port_word[ACK_BIT];
  assign wr    = port_word[WR_BIT];
  assign rd    = port_word[RD_BIT];
  assign rbyte = port_word[RDATA_LSB +: BYTE_W];
  assign wbyte = port_word[WDATA_LSB +: BYTE_W];
  assign addr  = port_word[ADDR_LSB +: ADDR_W];

  always_ff @(posedge clk) begin
    if (rst || !phy_req) busy_cnt <= '0;
    else                 busy_cnt <= busy_cnt + 1'b1;
  end

  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(phy_done)); // R3

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (ack && !wr && !rd) |=> !ack); // R4

  AST_RBYTE_HELD: assert property (@(posedge clk) disable iff (rst)
    (ack && $past(ack)) |-> $stable(rbyte)); // R5

  AST_NO_START_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_req) |-> $past(wr ^ rd)); // R6

  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (ack && $past(ack)) |-> ($stable(addr) && $stable(wbyte))); // R7

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    phy_req |-> (busy_cnt <= 16'(LAT))); // R10
endmodule

bind phy_access_bridge phy_access_bridge_chk #(.LAT(LAT)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .port_word (port_rdata),
  .phy_req   (phy_req),
  .phy_done  (phy_done)
);

// File: tb/phy_access_bridge_tb.sv
`timescale 1ns/1ps
module phy_access_bridge_tb_top;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_we = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] port_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  logic [7:0] model [64];
  logic [7:0] exp_q [$];
  logic       prev_ack = 1'b0;

  always #2.5 clk = ~clk;

  phy_access_bridge #(.LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata), .port_rdata(port_rdata)
  );

  function automatic logic [31:0] word(input logic w, input logic r,
                                       input logic [7:0] d, input logic [5:0] a);
    return {5'b0, 1'b0, r, w, 8'h00, d, 2'b00, a};
  endfunction

  function automatic logic supported(input int a);
    return (a <= 8) || (a >= 11 && a <= 13);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [31:0] v);
    @(negedge clk);
    sw_we = 1'b1;
    sw_wdata = v;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic wait_ack(input logic lvl, output int n);
    n = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      n = i;
      if (port_rdata[26] == lvl) break;
    end
  endtask

  task automatic release_req(input logic [7:0] d, input logic [5:0] a);
    sw_write(word(1'b0, 1'b0, d, a));
    check(port_rdata[26] == 1'b1, "R4 ack held one edge", port_rdata[26], 1);
    @(negedge clk);
    check(port_rdata[26] == 1'b0, "R4 ack falls after clear", port_rdata[26], 0);
  endtask

  task automatic phy_write(input logic [5:0] a, input logic [7:0] d);
    int n;
    sw_write(word(1'b0, 1'b0, d, a));
    sw_write(word(1'b1, 1'b0, d, a));
    wait_ack(1'b1, n);
    check(port_rdata[26] == 1'b1 && n <= LAT + 2, "R10 write ack bound", n, LAT + 2);
    if (supported(a)) model[a] = d;
    release_req(d, a);
  endtask

  task automatic phy_read(input logic [5:0] a);
    int n;
    logic [7:0] held;
    exp_q.push_back(supported(a) ? model[a] : 8'h00);
    sw_write(word(1'b0, 1'b0, 8'h00, a));
    sw_write(word(1'b0, 1'b1, 8'h00, a));
    wait_ack(1'b1, n);
    check(port_rdata[26] == 1'b1 && n <= LAT + 2, "R10 read ack bound", n, LAT + 2);
    held = port_rdata[23:16];
    sw_write(word(1'b0, 1'b1, 8'hA5, ~a));
    check(port_rdata[15:0] == {8'h00, 2'b00, a}, "R7 fields frozen under ack",
          port_rdata[15:0], {8'h00, 2'b00, a});
    check(port_rdata[23:16] == held, "R5 read byte held", port_rdata[23:16], held);
    release_req(8'h00, a);
  endtask

  // monitor: compare read byte when acknowledge rises on a read
  always @(negedge clk) begin
    if (!rst && port_rdata[26] && !prev_ack && port_rdata[25]) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected read completion", port_rdata[23:16], 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(port_rdata[23:16] == e, "R3 R5 R8 read byte", port_rdata[23:16], e);
      end
    end
    prev_ack <= port_rdata[26];
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      n_fails++;
      $display("FAIL R10 watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pat;
    logic [5:0] live [12];
    int n;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    for (int i = 0; i < 9; i++) live[i] = 6'(i);
    live[9] = 6'd11; live[10] = 6'd12; live[11] = 6'd13;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(port_rdata == 32'h0, "R1 reset register", port_rdata, 0);
    phy_read(6'h05);

    // R2 field layout readback
    sw_write(word(1'b0, 1'b0, 8'h3C, 6'h2A));
    check(port_rdata == 32'h0000_3C2A, "R2 layout", port_rdata, 32'h0000_3C2A);
    // R9 ack and read byte not writable
    sw_write(32'h04FF_0000 | word(1'b0, 1'b0, 8'h11, 6'h01));
    check(port_rdata == 32'h0000_1101, "R9 status bits", port_rdata, 32'h0000_1101);

    // R3 writes with distinct patterns at edge addresses
    phy_write(6'h00, 8'h5A);
    phy_write(6'h08, 8'hFF);
    phy_write(6'h0B, 8'h01);
    phy_write(6'h0D, 8'h80);
    phy_read(6'h00);
    phy_read(6'h08);
    phy_read(6'h0B);
    phy_read(6'h0D);

    // R8 unsupported addresses
    phy_write(6'h09, 8'h77);
    phy_write(6'h3F, 8'h66);
    phy_read(6'h09);
    phy_read(6'h3F);

    // R6 both requests set
    sw_write(word(1'b0, 1'b0, 8'hEE, 6'h00));
    sw_write(word(1'b1, 1'b1, 8'hEE, 6'h00));
    wait_ack(1'b1, n);
    check(port_rdata[26] == 1'b0, "R6 no ack on both requests", port_rdata[26], 0);
    sw_write(word(1'b0, 1'b0, 8'hEE, 6'h00));
    phy_read(6'h00);

    // full rewrite of every setting, one handshake each (R3)
    for (int k = 0; k < 12; k++) begin
      pat = 8'(8'h13 * (k + 1) ^ 8'hC3);
      phy_write(live[k], pat);
    end
    for (int k = 0; k < 12; k++) phy_read(live[k]);

    // R1 reset wipes PHY settings
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    check(port_rdata == 32'h0, "R1 reset register again", port_rdata, 0);
    phy_read(6'h0C);
    phy_read(6'h03);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 all reads completed", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule